// File: doc/BRIEF.md
# Scan Port Monitor

This block listens to a four-wire boundary-scan test port (test clock, mode select, data in, data out) from a faster system clock and never drives any of those wires. It runs its own copy of the 16-state test access port controller. The copy advances on each rising test-clock edge using the mode-select level seen at that edge. Each advance produces a one-cycle event that carries the old state and the new state.

During instruction-register and data-register shifts, the monitor collects the data-in and data-out bit on every edge that lands in a Shift state. When the controller leaves Shift for Exit1, both bitstrings are handed off on a valid/ready interface. The hand-off also carries the bit count, a flag telling the instruction branch from the data branch, an overflow flag and a lost-result flag. The capture is then cleared so that the next shift starts empty.

Top module: `jtmon_top`

## Requirements
- R1: After reset the reported state is Run-Test/Idle (code 1), the event output is low and no result is valid.
- R2: State codes are: Test-Logic-Reset 0, Run-Test/Idle 1; data branch Select 2, Capture 3, Shift 4, Exit1 5, Pause 6, Exit2 7, Update 8; instruction branch Select 9, Capture 10, Shift 11, Exit1 12, Pause 13, Exit2 14, Update 15. Transitions follow the standard test access port graph, driven by mode select.
- R3: The state changes only on a rising test-clock edge, and each edge gives exactly one single-cycle event pulse. The pulse comes three system-clock edges after the test clock rises.
- R4: With each event, the previous-state output holds the state before the edge and the current-state output holds the state after it.
- R5: On every edge whose new state is a Shift state, one data-in bit and one data-out bit are captured. The first bit captured lands in bit 0 of the result, and each later bit goes one position higher.
- R6: A result is published on the edge that moves from a Shift state to an Exit1 state. It gives the count of stored bits and sets is_ir to 1 when that Exit1 state is in the instruction branch. The capture then restarts empty, so a shift resumed after Pause is reported as a new result.
- R7: The capture holds at most MAX_BITS bits (64). Bits beyond that are dropped, the count stays at 64 and the overflow flag is 1. A scan of exactly 64 bits leaves the overflow flag at 0.
- R8: A valid result stays valid with unchanged content until ready is high. If a new result arrives while the previous one is still pending, the new result replaces it and carries the lost flag set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed mode select |
| tdi_i | input | 1 | Observed data into the target |
| tdo_i | input | 1 | Observed data out of the target |
| st_evt_o | output | 1 | One-cycle pulse per test-clock rising edge |
| st_prev_o | output | 4 | State before the last edge |
| st_cur_o | output | 4 | State after the last edge |
| res_valid_o | output | 1 | Scan result available |
| res_ready_i | input | 1 | Consumer accepts result |
| res_is_ir_o | output | 1 | 1 for an instruction-register scan |
| res_len_o | output | 7 | Number of stored bits |
| res_tdi_o | output | 64 | Captured data-in bits, first bit at bit 0 |
| res_tdo_o | output | 64 | Captured data-out bits, first bit at bit 0 |
| res_ovf_o | output | 1 | Scan was longer than the capture |
| res_lost_o | output | 1 | A previous result was overwritten unaccepted |

## Verification
The assertions assume that the test clock stays high and low for at least two system-clock periods, so that no rising edge is missed and no two event pulses are adjacent. They also assume that mode select and both data lines are stable through the synchronizer window around each rising test-clock edge. The stimulus sets the data lines four system clocks before each rise, holds the test clock high for about five clocks and keeps it low for eight or more. It changes ready only while the test clock is idle.

// File: rtl/jtmon_pkg.sv
package jtmon_pkg;
  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SHF_DR = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SHF_IR = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_st_e;

  function automatic logic st_is_shift(tap_st_e s);
    return (s == ST_SHF_DR) || (s == ST_SHF_IR);
  endfunction

  function automatic logic st_is_exit1(tap_st_e s);
    return (s == ST_EX1_DR) || (s == ST_EX1_IR);
  endfunction
endpackage

// File: rtl/jtmon_sync.sv
module jtmon_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/jtmon_tap.sv
module jtmon_tap
  import jtmon_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rise_i,
  input  logic    tms_i,
  output tap_st_e cur_o,
  output tap_st_e prev_o,
  output tap_st_e nxt_o,
  output logic    evt_o
);
  tap_st_e cur_q, prev_q, nxt;
  logic    evt_q;

  always_comb begin
    unique case (cur_q)
      ST_TLR:    nxt = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms_i ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms_i ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms_i ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_RTI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= ST_RTI;
      prev_q <= ST_RTI;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= rise_i;
      if (rise_i) begin
        prev_q <= cur_q;
        cur_q  <= nxt;
      end
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
  assign nxt_o  = nxt;
  assign evt_o  = evt_q;

  AST_SEL_IR_TMS1_TLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && tms_i && cur_q == ST_SEL_IR) |=> (cur_q == ST_TLR)); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !tms_i && st_is_shift(cur_q)) |=> $stable(cur_q)); // R2
endmodule

// File: rtl/jtmon_capture.sv
module jtmon_capture
  import jtmon_pkg::*;
#(
  parameter int MAX_BITS = 64,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  tap_st_e             cur_i,
  input  tap_st_e             nxt_i,
  input  logic                tdi_i,
  input  logic                tdo_i,
  input  logic                rdy_i,
  output logic                valid_o,
  output logic                is_ir_o,
  output logic [LEN_W-1:0]    len_o,
  output logic [MAX_BITS-1:0] tdi_o,
  output logic [MAX_BITS-1:0] tdo_o,
  output logic                ovf_o,
  output logic                lost_o
);
  logic [MAX_BITS-1:0] tdi_acc, tdo_acc;
  logic [LEN_W-1:0]    cnt_q;
  logic                ovf_acc;
  logic                take, done, full;

  assign take = rise_i && st_is_shift(nxt_i);
  assign done = rise_i && st_is_shift(cur_i) && st_is_exit1(nxt_i);
  assign full = (cnt_q >= LEN_W'(MAX_BITS));

  // accumulator
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdi_acc <= '0;
      tdo_acc <= '0;
      cnt_q   <= '0;
      ovf_acc <= 1'b0;
    end else if (done) begin
      tdi_acc <= '0;
      tdo_acc <= '0;
      cnt_q   <= '0;
      ovf_acc <= 1'b0;
    end else if (take) begin
      if (full) begin
        ovf_acc <= 1'b1;
      end else begin
        tdi_acc[cnt_q[IDX_W-1:0]] <= tdi_i;
        tdo_acc[cnt_q[IDX_W-1:0]] <= tdo_i;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // result holding register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      is_ir_o <= 1'b0;
      len_o   <= '0;
      tdi_o   <= '0;
      tdo_o   <= '0;
      ovf_o   <= 1'b0;
      lost_o  <= 1'b0;
    end else if (done) begin
      valid_o <= 1'b1;
      is_ir_o <= (nxt_i == ST_EX1_IR);
      len_o   <= cnt_q;
      tdi_o   <= tdi_acc;
      tdo_o   <= tdo_acc;
      ovf_o   <= ovf_acc;
      lost_o  <= valid_o && !rdy_i;
    end else if (valid_o && rdy_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rdy_i && !done) |=> (valid_o && $stable(tdi_o) && $stable(len_o))); // R8
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o <= LEN_W'(MAX_BITS))); // R7
  AST_OVF_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (len_o == LEN_W'(MAX_BITS))); // R7
endmodule

// File: rtl/jtmon_top.sv
module jtmon_top
  import jtmon_pkg::*;
#(
  parameter int MAX_BITS    = 64,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tck_i,
  input  logic                tms_i,
  input  logic                tdi_i,
  input  logic                tdo_i,
  output logic                st_evt_o,
  output logic [3:0]          st_prev_o,
  output logic [3:0]          st_cur_o,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic                res_is_ir_o,
  output logic [LEN_W-1:0]    res_len_o,
  output logic [MAX_BITS-1:0] res_tdi_o,
  output logic [MAX_BITS-1:0] res_tdo_o,
  output logic                res_ovf_o,
  output logic                res_lost_o
);
  logic [3:0] pins_s;
  logic       tck_s, tms_s, tdi_s, tdo_s, tck_d, tck_rise;
  tap_st_e    cur, prev, nxt;

  jtmon_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tck_i, tms_i, tdi_i, tdo_i}),
    .q_o   (pins_s)
  );
  assign {tck_s, tms_s, tdi_s, tdo_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tck_d <= 1'b0;
    else         tck_d <= tck_s;
  end
  assign tck_rise = tck_s && !tck_d;

  jtmon_tap u_tap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(tck_rise),
    .tms_i (tms_s),
    .cur_o (cur),
    .prev_o(prev),
    .nxt_o (nxt),
    .evt_o (st_evt_o)
  );

  jtmon_capture #(.MAX_BITS(MAX_BITS)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (tck_rise),
    .cur_i  (cur),
    .nxt_i  (nxt),
    .tdi_i  (tdi_s),
    .tdo_i  (tdo_s),
    .rdy_i  (res_ready_i),
    .valid_o(res_valid_o),
    .is_ir_o(res_is_ir_o),
    .len_o  (res_len_o),
    .tdi_o  (res_tdi_o),
    .tdo_o  (res_tdo_o),
    .ovf_o  (res_ovf_o),
    .lost_o (res_lost_o)
  );

  assign st_cur_o  = cur;
  assign st_prev_o = prev;

  AST_STATE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tck_rise |=> $stable(st_cur_o)); // R3
  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_evt_o |=> !st_evt_o); // R3
  AST_PREV_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_evt_o |-> (st_prev_o == $past(st_cur_o))); // R4
  AST_PUBLISH_FROM_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> (st_evt_o && st_is_shift(prev) && st_is_exit1(cur))); // R6
endmodule

// File: tb/sim_jtmon_top.sv
`timescale 1ns/1ps
module sim_jtmon_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck_r = 1'b0, tms_r = 1'b0, tdi_r = 1'b0, tdo_r = 1'b0, rdy_r = 1'b0;
  logic        evt, valid, is_ir, ovf, lost;
  logic [3:0]  prev, cur;
  logic [6:0]  len;
  logic [63:0] rtdi, rtdo;

  always #2.5 clk = ~clk;

  jtmon_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .tck_i(tck_r), .tms_i(tms_r), .tdi_i(tdi_r), .tdo_i(tdo_r),
    .st_evt_o(evt), .st_prev_o(prev), .st_cur_o(cur), .res_valid_o(valid), .res_ready_i(rdy_r),
    .res_is_ir_o(is_ir), .res_len_o(len), .res_tdi_o(rtdi), .res_tdo_o(rtdo),
    .res_ovf_o(ovf), .res_lost_o(lost)
  );

  int checks = 0, fails = 0;
  bit mon_on = 0;

  // behavioural model
  int m_cur = 1, m_prev = 1;
  bit m_evt = 0, m_valid = 0;
  bit q_tdi[$], q_tdo[$];
  bit q_ovf = 0;
  logic [63:0] e_tdi, e_tdo;
  int e_len;
  bit e_ir, e_ovf, e_lost;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int nxt_st(int s, bit t);
    case (s)
      0: return t ? 0 : 1;
      1: return t ? 2 : 1;
      2: return t ? 9 : 3;
      9: return t ? 0 : 10;
      3, 4: return t ? 5 : 4;
      10, 11: return t ? 12 : 11;
      5: return t ? 8 : 6;
      12: return t ? 15 : 13;
      6: return t ? 7 : 6;
      13: return t ? 14 : 13;
      7: return t ? 8 : 4;
      14: return t ? 15 : 11;
      default: return t ? 2 : 1;
    endcase
  endfunction

  function automatic bit is_sh(int s);
    return s == 4 || s == 11;
  endfunction

  task automatic tick(bit t, bit di = 0, bit dout = 0);
    int n;
    @(negedge clk);
    tms_r = t; tdi_r = di; tdo_r = dout;
    repeat (4) @(negedge clk);
    tck_r = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n = nxt_st(m_cur, t);
    if (is_sh(n)) begin
      if (q_tdi.size() < 64) begin q_tdi.push_back(di); q_tdo.push_back(dout); end
      else q_ovf = 1;
    end
    if (is_sh(m_cur) && (n == 5 || n == 12)) begin
      e_lost = m_valid;
      m_valid = 1;
      e_tdi = '0; e_tdo = '0;
      foreach (q_tdi[i]) begin e_tdi[i] = q_tdi[i]; e_tdo[i] = q_tdo[i]; end
      e_len = q_tdi.size();
      e_ir = (n == 12);
      e_ovf = q_ovf;
      q_tdi.delete(); q_tdo.delete(); q_ovf = 0;
    end
    m_prev = m_cur; m_cur = n; m_evt = 1;
    @(negedge clk);
    m_evt = 0;
    tck_r = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk);
    rdy_r = 1'b1;
    @(negedge clk);
    m_valid = 0;
    rdy_r = 1'b0;
  endtask

  task automatic scan(bit ir, int n, logic [127:0] di, logic [127:0] dout);
    tick(1);
    if (ir) tick(1);
    tick(0);
    for (int i = 0; i < n; i++) tick(0, di[i], dout[i]);
    tick(1);
    tick(1);
    tick(0);
  endtask

  // per-cycle comparison
  always begin
    @(negedge clk);
    #1;
    if (mon_on) begin
      chk(evt == m_evt, "R3", "evt", 64'(evt), 64'(m_evt));
      chk(cur == 4'(m_cur), "R2", "cur", 64'(cur), 64'(m_cur));
      if (m_evt) chk(prev == 4'(m_prev), "R4", "prev", 64'(prev), 64'(m_prev));
      chk(valid == m_valid, "R8", "valid", 64'(valid), 64'(m_valid));
      if (m_valid && valid) begin
        chk(rtdi == e_tdi, "R5", "tdi", rtdi, e_tdi);
        chk(rtdo == e_tdo, "R5", "tdo", rtdo, e_tdo);
        chk(len == 7'(e_len), "R6", "len", 64'(len), 64'(e_len));
        chk(is_ir == e_ir, "R6", "is_ir", 64'(is_ir), 64'(e_ir));
        chk(ovf == e_ovf, "R7", "ovf", 64'(ovf), 64'(e_ovf));
        chk(lost == e_lost, "R8", "lost", 64'(lost), 64'(e_lost));
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(cur == 4'd1, "R1", "reset state", 64'(cur), 64'd1);
    chk(evt == 1'b0, "R1", "reset evt", 64'(evt), 64'd0);
    chk(valid == 1'b0, "R1", "reset valid", 64'(valid), 64'd0);
    mon_on = 1;
    // R2 walk through select branches to reset and back
    tick(1); tick(1); tick(1); tick(1); tick(0); tick(0);
    // R5 R6 data scan
    scan(0, 8, 128'hA5, 128'h3C);
    accept();
    // R6 instruction scan
    scan(1, 5, 128'h16, 128'h09);
    accept();
    // R6 split by pause, R8 lost result
    tick(1); tick(0);
    tick(0, 1, 0); tick(0, 0, 1);
    tick(1);
    tick(0); tick(0); tick(1);
    tick(0, 1, 1); tick(0, 1, 0); tick(0, 0, 1);
    tick(1);
    accept();
    tick(1); tick(0);
    // R7 overflow and exact fill
    scan(0, 70, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}, {64'h5555_0000_FFFF_AAAA, 64'h1357_9BDF_2468_ACE0});
    accept();
    scan(0, 64, 128'hDEAD_BEEF_CAFE_F00D, 128'h0F0F_1234_8765_F0F0);
    accept();
    scan(1, 1, 128'h1, 128'h0);
    accept();
    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R3 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule